// File: doc/BRIEF.md
# Dual-Clock Dual-Port Word Memory with Burst Address Counters

This block is a true dual-port synchronous memory. Two ports, A and B, each run on their own clock and can reach every word of the shared storage, including the same word at the same moment. On every rising edge of its clock, a port captures its address, write data and control inputs. From then on it works from those captured values. The default build holds 1024 words of 16 bits. Setting the address width parameter to 15 gives the full 32768-word array.

Each port keeps its own address register, which also works as a burst counter. On each edge the register is cleared, loaded from the address pins, stepped by one, or held. Holding the load strobe low gives a new random address every cycle. A port is selected only when its low-active select is low and its high-active select is high. Two low-active byte-lane enables choose which bytes a write stores or a read returns.

A per-port latency input sets the read path:
- In flow-through mode, read data appears in the cycle after the request is captured.
- In pipelined mode, the data appears one cycle later still, from an output register.

A low-active, combinational output enable gates the result. Instead of tri-state pins, each port reports a per-lane drive flag, and lanes that are not driven read as zero.

Top module: `dpram_dual_counter`

## Requirements
- R1: While reset is low, every drive flag and every read data bit of both ports is 0. After reset, the address register of each port is 0.
- R2: A write (read/write input low) from a selected port stores byte lane 0 (bits 7..0) when lane enable bit 0 is low, and byte lane 1 (bits 15..8) when lane enable bit 1 is low. A lane whose enable is high keeps its previous contents.
- R3: A port is selected only when its low-active select is 0 and its high-active select is 1. Any other combination writes nothing and drives nothing.
- R4: On each edge, the port's address register takes exactly one action, chosen in this priority: cleared to 0 when the clear input is low; otherwise loaded from the address pins when the strobe is low; otherwise stepped by one when the step input is low; otherwise held. This happens whether or not the port is selected.
- R5: In flow-through mode (latency input 0), a read captured at edge k shows its data and drive flags from edge k until edge k+1.
- R6: In pipelined mode (latency input 1), a read captured at edge k shows its data and drive flags from edge k+1 until edge k+2. Back-to-back reads come out one per cycle.
- R7: When the output enable is high, all drive flags of that port are 0 and its read data is 0 at once, without waiting for a clock edge.
- R8: A word written through either port can be read through either port. The two ports may read the same word in the same cycle.
- R9: A read drives only the lanes whose lane enable is low. Lanes that are not driven read as 0, and a write cycle drives no lane.
- R10: Stepping the address register from the all-ones address gives address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous low-active reset for both ports |
| a_ce_lo_n | input | 1 | Port A low-active select |
| a_ce_hi | input | 1 | Port A high-active select |
| a_rd_wr | input | 1 | Port A: 1 read, 0 write |
| a_lane_n | input | DW/8 | Port A low-active byte-lane enables |
| a_strobe_n | input | 1 | Port A low-active address load |
| a_step_n | input | 1 | Port A low-active counter step |
| a_zero_n | input | 1 | Port A low-active counter clear |
| a_addr | input | AW | Port A address pins |
| a_wdata | input | DW | Port A write data |
| a_pipe | input | 1 | Port A latency select: 1 pipelined, 0 flow-through |
| a_oe_n | input | 1 | Port A low-active output enable |
| a_rdata | output | DW | Port A read data |
| a_drive | output | DW/8 | Port A per-lane drive flags |
| b_ce_lo_n | input | 1 | Port B low-active select |
| b_ce_hi | input | 1 | Port B high-active select |
| b_rd_wr | input | 1 | Port B: 1 read, 0 write |
| b_lane_n | input | DW/8 | Port B low-active byte-lane enables |
| b_strobe_n | input | 1 | Port B low-active address load |
| b_step_n | input | 1 | Port B low-active counter step |
| b_zero_n | input | 1 | Port B low-active counter clear |
| b_addr | input | AW | Port B address pins |
| b_wdata | input | DW | Port B write data |
| b_pipe | input | 1 | Port B latency select: 1 pipelined, 0 flow-through |
| b_oe_n | input | 1 | Port B low-active output enable |
| b_rdata | output | DW | Port B read data |
| b_drive | output | DW/8 | Port B per-lane drive flags |

## Verification
A request captured at edge k has two possible due times. In flow-through mode its result is due between edge k and edge k+1. In pipelined mode it is due between edge k+1 and edge k+2. A write lands at edge k+1, so any later request sees it.

The bench drives and samples each port on the falling edge of that port's own clock. For a flow-through request it samples at the first falling edge after capture, and for a pipelined request at the second. The back-to-back cases sample each of two results at their own falling edge. The bench tracks each port's address register using the same priority order as the design. The output-enable case is checked a fraction of a nanosecond after the pin changes, with no clock edge in between.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;

  typedef enum logic [1:0] {
    AOP_HOLD = 2'd0,
    AOP_STEP = 2'd1,
    AOP_LOAD = 2'd2,
    AOP_ZERO = 2'd3
  } addr_op_e;

  // Clear beats load, load beats step.
  function automatic addr_op_e pick_addr_op(input logic zero_n, input logic strobe_n,
                                            input logic step_n);
    if (!zero_n)   return AOP_ZERO;
    if (!strobe_n) return AOP_LOAD;
    if (!step_n)   return AOP_STEP;
    return AOP_HOLD;
  endfunction

  function automatic logic port_selected(input logic ce_lo_n, input logic ce_hi);
    return !ce_lo_n && ce_hi;
  endfunction

  // A lane belongs to bank A when the two tag bits differ.
  function automatic logic owner_is_a(input logic tag_a, input logic tag_b);
    return tag_a ^ tag_b;
  endfunction

endpackage

// File: rtl/dpram_port_front.sv
`timescale 1ns/1ps
module dpram_port_front #(
  parameter int AW    = 10,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_lo_n,
  input  logic             ce_hi,
  input  logic             rd_wr,
  input  logic [LANES-1:0] lane_n,
  input  logic             strobe_n,
  input  logic             step_n,
  input  logic             zero_n,
  input  logic [AW-1:0]    addr_in,
  input  logic [DW-1:0]    wdata_in,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    wdata_q,
  output logic [LANES-1:0] wr_lane_q,
  output logic [LANES-1:0] rd_lane_q,
  output logic             sel_q
);
  import dpram_pkg::*;

  addr_op_e addr_op;
  logic     sel_now;

  assign addr_op = pick_addr_op(zero_n, strobe_n, step_n);
  assign sel_now = port_selected(ce_lo_n, ce_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      unique case (addr_op)
        AOP_ZERO: addr_q <= '0;
        AOP_LOAD: addr_q <= addr_in;
        AOP_STEP: addr_q <= addr_q + 1'b1;
        default:  addr_q <= addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q   <= '0;
      wr_lane_q <= '0;
      rd_lane_q <= '0;
      sel_q     <= 1'b0;
    end else begin
      wdata_q   <= wdata_in;
      sel_q     <= sel_now;
      wr_lane_q <= (sel_now && !rd_wr) ? ~lane_n : '0;
      rd_lane_q <= (sel_now &&  rd_wr) ? ~lane_n : '0;
    end
  end

endmodule

// File: rtl/dpram_xor_store.sv
`timescale 1ns/1ps
module dpram_xor_store #(
  parameter int AW    = 10,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk_a,
  input  logic [LANES-1:0] we_a,
  input  logic [AW-1:0]    addr_a,
  input  logic [DW-1:0]    din_a,
  output logic [DW-1:0]    dout_a,
  input  logic             clk_b,
  input  logic [LANES-1:0] we_b,
  input  logic [AW-1:0]    addr_b,
  input  logic [DW-1:0]    din_b,
  output logic [DW-1:0]    dout_b
);
  import dpram_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] bank_a [DEPTH];
    logic [LW-1:0] bank_b [DEPTH];
    logic          tag_a  [DEPTH];
    logic          tag_b  [DEPTH];

    always_ff @(posedge clk_a) begin
      if (we_a[g]) begin
        bank_a[addr_a] <= din_a[g*LW +: LW];
        tag_a[addr_a]  <= ~tag_b[addr_a];
      end
    end

    always_ff @(posedge clk_b) begin
      if (we_b[g]) begin
        bank_b[addr_b] <= din_b[g*LW +: LW];
        tag_b[addr_b]  <= tag_a[addr_b];
      end
    end

    assign dout_a[g*LW +: LW] = owner_is_a(tag_a[addr_a], tag_b[addr_a]) ?
                                bank_a[addr_a] : bank_b[addr_a];
    assign dout_b[g*LW +: LW] = owner_is_a(tag_a[addr_b], tag_b[addr_b]) ?
                                bank_a[addr_b] : bank_b[addr_b];
  end

endmodule

// File: rtl/dpram_out_stage.sv
`timescale 1ns/1ps
module dpram_out_stage #(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             oe_n,
  input  logic [LANES-1:0] rd_lane_q,
  input  logic [DW-1:0]    rdata,
  output logic [DW-1:0]    dout,
  output logic [LANES-1:0] drive
);
  localparam int LW = DW / LANES;

  function automatic logic [DW-1:0] widen(input logic [LANES-1:0] lanes);
    logic [DW-1:0] w;
    for (int i = 0; i < LANES; i++) w[i*LW +: LW] = {LW{lanes[i]}};
    return w;
  endfunction

  logic [LANES-1:0] pipe_lane;
  logic [DW-1:0]    pipe_data;
  logic [LANES-1:0] src_lane;
  logic [DW-1:0]    src_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_lane <= '0;
      pipe_data <= '0;
    end else begin
      pipe_lane <= rd_lane_q;
      pipe_data <= rdata & widen(rd_lane_q);
    end
  end

  assign src_lane = pipe_mode ? pipe_lane : rd_lane_q;
  assign src_data = pipe_mode ? pipe_data : rdata;
  assign drive    = oe_n ? '0 : src_lane;
  assign dout     = src_data & widen(drive);

endmodule

// File: rtl/dpram_dual_counter.sv
`timescale 1ns/1ps
module dpram_dual_counter #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic            clk_a,
  input  logic            clk_b,
  input  logic            rst_n,
  input  logic            a_ce_lo_n,
  input  logic            a_ce_hi,
  input  logic            a_rd_wr,
  input  logic [DW/8-1:0] a_lane_n,
  input  logic            a_strobe_n,
  input  logic            a_step_n,
  input  logic            a_zero_n,
  input  logic [AW-1:0]   a_addr,
  input  logic [DW-1:0]   a_wdata,
  input  logic            a_pipe,
  input  logic            a_oe_n,
  output logic [DW-1:0]   a_rdata,
  output logic [DW/8-1:0] a_drive,
  input  logic            b_ce_lo_n,
  input  logic            b_ce_hi,
  input  logic            b_rd_wr,
  input  logic [DW/8-1:0] b_lane_n,
  input  logic            b_strobe_n,
  input  logic            b_step_n,
  input  logic            b_zero_n,
  input  logic [AW-1:0]   b_addr,
  input  logic [DW-1:0]   b_wdata,
  input  logic            b_pipe,
  input  logic            b_oe_n,
  output logic [DW-1:0]   b_rdata,
  output logic [DW/8-1:0] b_drive
);
  localparam int LANES = DW / 8;

  logic [AW-1:0]    a_addr_q,    b_addr_q;
  logic [DW-1:0]    a_wdata_q,   b_wdata_q;
  logic [LANES-1:0] a_wr_lane_q, b_wr_lane_q;
  logic [LANES-1:0] a_rd_lane_q, b_rd_lane_q;
  logic             a_sel_q,     b_sel_q;
  logic [DW-1:0]    a_array_q,   b_array_q;

  dpram_port_front #(.AW(AW), .DW(DW), .LANES(LANES)) u_front_a (
    .clk(clk_a), .rst_n(rst_n), .ce_lo_n(a_ce_lo_n), .ce_hi(a_ce_hi),
    .rd_wr(a_rd_wr), .lane_n(a_lane_n), .strobe_n(a_strobe_n),
    .step_n(a_step_n), .zero_n(a_zero_n), .addr_in(a_addr), .wdata_in(a_wdata),
    .addr_q(a_addr_q), .wdata_q(a_wdata_q), .wr_lane_q(a_wr_lane_q),
    .rd_lane_q(a_rd_lane_q), .sel_q(a_sel_q)
  );

  dpram_port_front #(.AW(AW), .DW(DW), .LANES(LANES)) u_front_b (
    .clk(clk_b), .rst_n(rst_n), .ce_lo_n(b_ce_lo_n), .ce_hi(b_ce_hi),
    .rd_wr(b_rd_wr), .lane_n(b_lane_n), .strobe_n(b_strobe_n),
    .step_n(b_step_n), .zero_n(b_zero_n), .addr_in(b_addr), .wdata_in(b_wdata),
    .addr_q(b_addr_q), .wdata_q(b_wdata_q), .wr_lane_q(b_wr_lane_q),
    .rd_lane_q(b_rd_lane_q), .sel_q(b_sel_q)
  );

  dpram_xor_store #(.AW(AW), .DW(DW), .LANES(LANES)) u_store (
    .clk_a(clk_a), .we_a(a_wr_lane_q), .addr_a(a_addr_q), .din_a(a_wdata_q),
    .dout_a(a_array_q),
    .clk_b(clk_b), .we_b(b_wr_lane_q), .addr_b(b_addr_q), .din_b(b_wdata_q),
    .dout_b(b_array_q)
  );

  dpram_out_stage #(.DW(DW), .LANES(LANES)) u_out_a (
    .clk(clk_a), .rst_n(rst_n), .pipe_mode(a_pipe), .oe_n(a_oe_n),
    .rd_lane_q(a_rd_lane_q), .rdata(a_array_q), .dout(a_rdata), .drive(a_drive)
  );

  dpram_out_stage #(.DW(DW), .LANES(LANES)) u_out_b (
    .clk(clk_b), .rst_n(rst_n), .pipe_mode(b_pipe), .oe_n(b_oe_n),
    .rd_lane_q(b_rd_lane_q), .rdata(b_array_q), .dout(b_rdata), .drive(b_drive)
  );

endmodule

// File: rtl/dpram_port_chk.sv
`timescale 1ns/1ps
module dpram_port_chk #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            zero_n,
  input logic            strobe_n,
  input logic            step_n,
  input logic [AW-1:0]   addr_in,
  input logic [AW-1:0]   addr_q,
  input logic            sel_q,
  input logic [DW/8-1:0] wr_lane_q,
  input logic [DW/8-1:0] rd_lane_q,
  input logic            pipe,
  input logic            oe_n,
  input logic [DW/8-1:0] drive,
  input logic [DW-1:0]   dout
);
  localparam int LANES = DW / 8;

  function automatic logic [DW-1:0] idle_bits(input logic [LANES-1:0] drv, input logic [DW-1:0] d);
    logic [DW-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = drv[i] ? 8'h00 : d[i*8 +: 8];
    return m;
  endfunction

  AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |=> addr_q == '0);                                           // R4
  AST_LOAD_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && !strobe_n) |=> addr_q == $past(addr_in));                // R4
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && strobe_n && !step_n) |=> addr_q == AW'($past(addr_q) + 1'b1)); // R10
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && strobe_n && step_n) |=> $stable(addr_q));                 // R4
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> (wr_lane_q == '0 && rd_lane_q == '0));                   // R3
  AST_NO_RW_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lane_q & rd_lane_q) == '0);                                     // R2
  AST_OE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (drive == '0 && dout == '0));                              // R7
  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    idle_bits(drive, dout) == '0);                                      // R9
  AST_FLOW_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && !oe_n) |-> drive == rd_lane_q);                           // R5
  AST_PIPE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && $past(pipe) && !oe_n) |-> drive == $past(rd_lane_q));      // R6

endmodule

bind dpram_dual_counter dpram_port_chk #(.AW(AW), .DW(DW)) u_chk_a (
  .clk(clk_a), .rst_n(rst_n), .zero_n(a_zero_n), .strobe_n(a_strobe_n),
  .step_n(a_step_n), .addr_in(a_addr), .addr_q(a_addr_q), .sel_q(a_sel_q),
  .wr_lane_q(a_wr_lane_q), .rd_lane_q(a_rd_lane_q), .pipe(a_pipe),
  .oe_n(a_oe_n), .drive(a_drive), .dout(a_rdata)
);

bind dpram_dual_counter dpram_port_chk #(.AW(AW), .DW(DW)) u_chk_b (
  .clk(clk_b), .rst_n(rst_n), .zero_n(b_zero_n), .strobe_n(b_strobe_n),
  .step_n(b_step_n), .addr_in(b_addr), .addr_q(b_addr_q), .sel_q(b_sel_q),
  .wr_lane_q(b_wr_lane_q), .rd_lane_q(b_rd_lane_q), .pipe(b_pipe),
  .oe_n(b_oe_n), .drive(b_drive), .dout(b_rdata)
);

// File: tb/dpram_dual_counter_tb.sv
`timescale 1ns/1ps
module dpram_dual_counter_tb;
  localparam int AW    = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  always #2 clk_a = ~clk_a;
  initial begin #1; forever #2 clk_b = ~clk_b; end

  logic [1:0]    ce_lo_n, ce_hi, rd_wr, strobe_n, step_n, zero_n, pipe_m, oe_n;
  logic [1:0]    lane_n [2];
  logic [AW-1:0] addr   [2];
  logic [DW-1:0] wdata  [2];
  logic [DW-1:0] dout   [2];
  logic [1:0]    drive  [2];

  dpram_dual_counter #(.AW(AW), .DW(DW)) u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_ce_lo_n(ce_lo_n[0]), .a_ce_hi(ce_hi[0]), .a_rd_wr(rd_wr[0]), .a_lane_n(lane_n[0]),
    .a_strobe_n(strobe_n[0]), .a_step_n(step_n[0]), .a_zero_n(zero_n[0]),
    .a_addr(addr[0]), .a_wdata(wdata[0]), .a_pipe(pipe_m[0]), .a_oe_n(oe_n[0]),
    .a_rdata(dout[0]), .a_drive(drive[0]),
    .b_ce_lo_n(ce_lo_n[1]), .b_ce_hi(ce_hi[1]), .b_rd_wr(rd_wr[1]), .b_lane_n(lane_n[1]),
    .b_strobe_n(strobe_n[1]), .b_step_n(step_n[1]), .b_zero_n(zero_n[1]),
    .b_addr(addr[1]), .b_wdata(wdata[1]), .b_pipe(pipe_m[1]), .b_oe_n(oe_n[1]),
    .b_rdata(dout[1]), .b_drive(drive[1])
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] ref_mem  [DEPTH];
  logic [AW-1:0] ref_addr [2];

  function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] cur, input logic zn,
                                             input logic sn, input logic stn, input logic [AW-1:0] ain);
    if (zn == 1'b0) return '0;
    else if (sn == 1'b0) return ain;
    else if (stn == 1'b0) return cur + 1'b1;
    return cur;
  endfunction

  function automatic logic [DW-1:0] lane_bits(input logic [1:0] l);
    return {{8{l[1]}}, {8{l[0]}}};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int p);
    if (p == 0) @(negedge clk_a); else @(negedge clk_b);
  endtask

  task automatic set_idle(input int p);
    ce_lo_n[p] = 1'b1; ce_hi[p] = 1'b0; rd_wr[p] = 1'b1; lane_n[p] = 2'b11;
    strobe_n[p] = 1'b1; step_n[p] = 1'b1; zero_n[p] = 1'b1;
  endtask

  // One request on port p; result sampled when due (R5 flow, R6 pipelined).
  task automatic access(input int p, input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] ln, input logic cl, input logic ch, input logic sn,
                        input logic stn, input logic zn, input bit pm, input bit oen, input string tag);
    logic [1:0] exp_l;
    logic sel;
    tick(p);
    pipe_m[p] = pm; oe_n[p] = oen;
    ce_lo_n[p] = cl; ce_hi[p] = ch; rd_wr[p] = rd; lane_n[p] = ln;
    strobe_n[p] = sn; step_n[p] = stn; zero_n[p] = zn; addr[p] = a; wdata[p] = d;
    tick(p);
    ref_addr[p] = ref_next(ref_addr[p], zn, sn, stn, a);
    set_idle(p);
    sel = !cl && ch;
    if (sel && !rd)
      ref_mem[ref_addr[p]] = (ref_mem[ref_addr[p]] & ~lane_bits(~ln)) | (d & lane_bits(~ln));
    exp_l = (sel && rd && !oen) ? ~ln : 2'b00;
    if (pm) tick(p);
    check({tag, " drive"}, 32'(drive[p]), 32'(exp_l));
    check({tag, " data"},  32'(dout[p]),  32'(ref_mem[ref_addr[p]] & lane_bits(exp_l)));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] x;
    void'($urandom(32'd20240611));
    for (int p = 0; p < 2; p++) begin
      set_idle(p); pipe_m[p] = 1'b0; oe_n[p] = 1'b0; addr[p] = '0; wdata[p] = '0; ref_addr[p] = '0;
    end
    #9;
    // R1: outputs quiet during reset
    check("R1 reset drive a", 32'(drive[0]), 0);
    check("R1 reset data a",  32'(dout[0]),  0);
    check("R1 reset drive b", 32'(drive[1]), 0);
    check("R1 reset data b",  32'(dout[1]),  0);
    rst_n = 1'b1;
    // R1: address register starts at 0 (hold, write), then R8 read back on B
    access(0, 0, 10'h155, 16'hA5C3, 2'b00, 0, 1, 1, 1, 1, 0, 0, "R1 write at reset addr");
    access(1, 1, 10'h000, 16'h0,    2'b00, 0, 1, 0, 1, 1, 0, 0, "R1 R8 read addr 0");
    // Preload every word, alternating ports (R8)
    for (int i = 0; i < DEPTH; i++)
      access(i % 2, 0, AW'(i), 16'($urandom), 2'b00, 0, 1, 0, 1, 1, 0, 0, "R8 preload");
    // R2 / R9: lane writes and lane reads
    access(0, 0, 10'h020, 16'h1234, 2'b00, 0, 1, 0, 1, 1, 0, 0, "R2 full write");
    access(1, 0, 10'h020, 16'hABCD, 2'b10, 0, 1, 0, 1, 1, 0, 0, "R2 low lane write");
    access(0, 1, 10'h020, 16'h0,    2'b00, 0, 1, 0, 1, 1, 0, 0, "R2 low lane result");
    check("R2 stored word", 32'(dout[0]), 32'h12CD);
    access(0, 0, 10'h020, 16'h77EE, 2'b01, 0, 1, 0, 1, 1, 0, 0, "R2 high lane write");
    access(1, 1, 10'h020, 16'h0,    2'b01, 0, 1, 0, 1, 1, 0, 0, "R9 high lane read");
    check("R9 high lane only", 32'(dout[1]), 32'h7700);
    access(1, 1, 10'h020, 16'h0,    2'b10, 0, 1, 0, 1, 1, 1, 0, "R9 R6 low lane pipelined");
    check("R9 low lane only", 32'(dout[1]), 32'h00CD);
    // R3: deselect combinations
    access(0, 0, 10'h030, 16'hDEAD, 2'b00, 1, 1, 0, 1, 1, 0, 0, "R3 lo_n high write");
    access(1, 0, 10'h030, 16'hBEEF, 2'b00, 0, 0, 0, 1, 1, 0, 0, "R3 hi low write");
    access(0, 0, 10'h030, 16'hF00D, 2'b00, 1, 0, 0, 1, 1, 0, 0, "R3 both off write");
    access(1, 1, 10'h030, 16'h0,    2'b00, 1, 1, 0, 1, 1, 0, 0, "R3 deselected read");
    access(0, 1, 10'h030, 16'h0,    2'b00, 0, 1, 0, 1, 1, 0, 0, "R3 word untouched");
    // R4 / R10: address register priorities and wrap
    access(0, 1, 10'h3FF, 16'h0, 2'b00, 0, 1, 0, 1, 1, 0, 0, "R10 load top");
    access(0, 1, 10'h155, 16'h0, 2'b00, 0, 1, 1, 0, 1, 0, 0, "R10 step wraps to 0");
    check("R10 wrap address", 32'(ref_addr[0]), 0);
    access(1, 1, 10'h005, 16'h0, 2'b00, 0, 1, 0, 0, 0, 0, 0, "R4 clear beats load");
    access(1, 1, 10'h044, 16'h0, 2'b00, 0, 1, 0, 0, 1, 0, 0, "R4 load beats step");
    access(1, 1, 10'h099, 16'h0, 2'b00, 0, 1, 1, 1, 1, 0, 0, "R4 hold");
    access(1, 1, 10'h099, 16'h0, 2'b00, 1, 0, 1, 0, 1, 0, 0, "R4 step while deselected");
    access(1, 1, 10'h099, 16'h0, 2'b00, 0, 1, 1, 1, 1, 0, 0, "R4 read after deselected step");
    // R8: both ports read the same word together
    fork
      access(0, 1, 10'h077, 16'h0, 2'b00, 0, 1, 0, 1, 1, 0, 0, "R8 same word port A");
      access(1, 1, 10'h077, 16'h0, 2'b00, 0, 1, 0, 1, 1, 1, 0, "R8 same word port B");
    join
    // R6: back-to-back pipelined reads on B
    x = 10'h2A0;
    tick(1);
    pipe_m[1] = 1; oe_n[1] = 0; ce_lo_n[1] = 0; ce_hi[1] = 1; rd_wr[1] = 1; lane_n[1] = 2'b00;
    strobe_n[1] = 0; addr[1] = x;
    tick(1);
    strobe_n[1] = 1; step_n[1] = 0;
    tick(1);
    check("R6 first pipelined", 32'(dout[1]), 32'(ref_mem[x]));
    set_idle(1);
    tick(1);
    check("R6 second pipelined", 32'(dout[1]), 32'(ref_mem[x + 1]));
    ref_addr[1] = x + 1;
    // R5: back-to-back flow-through reads on A, then R7 output enable
    tick(0);
    pipe_m[0] = 0; oe_n[0] = 0; ce_lo_n[0] = 0; ce_hi[0] = 1; rd_wr[0] = 1; lane_n[0] = 2'b00;
    strobe_n[0] = 0; addr[0] = x;
    tick(0);
    check("R5 first flow", 32'(dout[0]), 32'(ref_mem[x]));
    strobe_n[0] = 1; step_n[0] = 0;
    tick(0);
    check("R5 second flow", 32'(dout[0]), 32'(ref_mem[x + 1]));
    set_idle(0);
    ref_addr[0] = x + 1;
    oe_n[0] = 1; #0.3;
    check("R7 oe high drive", 32'(drive[0]), 0);
    check("R7 oe high data",  32'(dout[0]), 0);
    oe_n[0] = 0; #0.3;
    check("R7 oe low restores", 32'(dout[0]), 32'(ref_mem[x + 1]));
    // Random mix
    for (int n = 0; n < 600; n++) begin
      int p = int'($urandom_range(1, 0));
      int r = int'($urandom_range(9, 0));
      int cs = int'($urandom_range(7, 0));
      access(p, $urandom_range(1, 0) == 1, AW'($urandom), 16'($urandom), 2'($urandom),
             cs == 0, cs != 1, !(r < 7), !(r == 7), !(r == 8),
             $urandom_range(1, 0) == 1, $urandom_range(7, 0) == 0, "R2 R4 R5 R6 R8 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule